// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a processor's bus and watches every cycle. It requests a break when a cycle meets the conditions programmed into one or both of its two channels. Each channel compares the cycle address, with a coded choice of how many low bits to ignore. It also compares an address-space identifier that can be switched off. A qualifier then limits the match by access size, by read or write, and by instruction fetch or data access. The second channel can also compare the 32-bit data value under a per-bit mask.

A shared control register chooses how the channels combine. In the independent mode either channel breaks on its own. In the chained mode a channel A match arms the sequence, and a later channel B match completes it. For each channel, the control register also decides whether an instruction-fetch break is raised at once or held until the next instruction retire strobe. The same register holds one sticky matched flag per channel. Software programs the block through a flat register port with separate write and read addresses. The read port is combinational.

Top module: `bkpt_unit`

## Requirements
- R1: After reset every register reads zero and `break_o` is low. With the default qualifier of zero neither channel can match, so no break and no flag appear until software programs a channel.
- R2: The address mask code is taken from bits {3,1,0} of a channel's mask register. Code 0x0 compares all 32 address bits, 0x1 ignores the low 10 bits, 0x2 the low 12, 0x8 the low 16, 0x9 the low 20, and 0x3 ignores the whole address. Any other code compares all bits.
- R3: The 8-bit identifier of the cycle must equal the channel's identifier register. Bit 2 of the mask register removes this condition.
- R4: The size code in qualifier bits {6,1,0} selects one size: 0x01 byte (`cyc_size_i`=0), 0x02 16-bit (1), 0x03 32-bit (2), 0x40 64-bit (3). Zero accepts any size, and any other value accepts none.
- R5: Qualifier bit 2 accepts reads and bit 3 accepts writes. Bit 4 accepts instruction fetches and bit 5 accepts data accesses. If neither direction bit is set, or neither type bit is set, the channel never matches.
- R6: When control bit 7 is set, channel B also requires `((cyc_data_i ^ data) & ~dmask) == 0`, where a dmask bit of 1 ignores that data bit. Channel A has no data compare.
- R7: With control bit 3 clear, a match on either channel raises `break_o` in the same cycle as the matching bus cycle.
- R8: With control bit 3 set, a channel B match breaks only if the channel A flag was already set in an earlier cycle and the sequence is not spent. That break spends the sequence. It opens again only after a write of zero to the A flag.
- R9: Control bit 10 (A) and bit 6 (B) defer a break caused by an instruction-fetch match to the next cycle with `retire_i` high. Data-access matches still break at once.
- R10: Control bit 15 is the A matched flag and bit 14 is the B matched flag. A channel match sets its flag at the next edge. Writing 0 clears a flag, and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R11: The register indices are: A at 0 (address), 1 (mask, 4 bits), 2 (identifier, 8), 3 (qualifier, 7). B at 4 to 7 in the same order, 8 (data) and 9 (data mask). Control is at 10. Bits not implemented and indices 11 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_waddr_i | input | 4 | Register write index |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 4 | Register read index |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cyc_valid_i | input | 1 | A bus cycle is present |
| cyc_addr_i | input | 32 | Cycle address |
| cyc_asid_i | input | 8 | Cycle address-space identifier |
| cyc_size_i | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| cyc_write_i | input | 1 | 1 for a write, 0 for a read |
| cyc_insn_i | input | 1 | 1 for an instruction fetch, 0 for data |
| cyc_data_i | input | 32 | Cycle data value |
| retire_i | input | 1 | Instruction retire strobe |
| break_o | output | 1 | Break request pulse |

## Verification
Two pairs of events can land in the same clock cycle. In the first, a software write clears a matched flag while a channel matches; the bench drives the clearing write together with a hitting bus cycle, and the flag must still read set afterwards. In the second, `retire_i` releases a held break while a new instruction-fetch match is being deferred; `break_o` must pulse for the old match, and the new one must wait for the following retire. The read address stays on the control register for most of the run, so the reference model compares the flags, as well as `break_o`, on every clock.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int MSK_NOASID = 2;
  localparam int QL_RD  = 2;
  localparam int QL_WR  = 3;
  localparam int QL_INS = 4;
  localparam int QL_DAT = 5;

  typedef struct packed {
    logic a_flag;
    logic b_flag;
    logic a_after;
    logic b_data;
    logic b_after;
    logic chain;
  } ctl_t;

  typedef enum logic {SEQ_OPEN = 1'b0, SEQ_SPENT = 1'b1} seq_e;

  function automatic ctl_t ctl_unpack(input logic [15:0] w);
    ctl_t c;
    c.a_flag  = w[15];
    c.b_flag  = w[14];
    c.a_after = w[10];
    c.b_data  = w[7];
    c.b_after = w[6];
    c.chain   = w[3];
    return c;
  endfunction

  function automatic logic [15:0] ctl_pack(input ctl_t c);
    logic [15:0] w;
    w      = '0;
    w[15]  = c.a_flag;
    w[14]  = c.b_flag;
    w[10]  = c.a_after;
    w[7]   = c.b_data;
    w[6]   = c.b_after;
    w[3]   = c.chain;
    return w;
  endfunction

  // code = {mask[3], mask[1:0]}
  function automatic logic [4:0] ign_width(input logic [2:0] code);
    case (code)
      3'b001:  return 5'd10;
      3'b010:  return 5'd12;
      3'b100:  return 5'd16;
      3'b101:  return 5'd20;
      default: return 5'd0;
    endcase
  endfunction

  // code = {qual[6], qual[1:0]}
  function automatic logic size_ok(input logic [2:0] code, input logic [1:0] sz);
    case (code)
      3'b000:  return 1'b1;
      3'b001:  return sz == 2'd0;
      3'b010:  return sz == 2'd1;
      3'b011:  return sz == 2'd2;
      3'b100:  return sz == 2'd3;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bkpt_chan.sv
module bkpt_chan
  import bkpt_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned IW   = 8,
  parameter int unsigned RW   = 32,
  parameter int unsigned RA_W = 4,
  parameter int unsigned BASE = 0,
  parameter bit          HAS_DATA = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RA_W-1:0] waddr_i,
  input  logic [RW-1:0]   wdata_i,
  input  logic [RA_W-1:0] raddr_i,
  output logic [RW-1:0]   rdata_o,
  input  logic            cyc_valid_i,
  input  logic [AW-1:0]   cyc_addr_i,
  input  logic [IW-1:0]   cyc_asid_i,
  input  logic [1:0]      cyc_size_i,
  input  logic            cyc_write_i,
  input  logic            cyc_insn_i,
  input  logic [DW-1:0]   cyc_data_i,
  input  logic            data_en_i,
  output logic            hit_o
);

  localparam logic [RA_W-1:0] R_ADDR = RA_W'(BASE);
  localparam logic [RA_W-1:0] R_MASK = RA_W'(BASE + 1);
  localparam logic [RA_W-1:0] R_ASID = RA_W'(BASE + 2);
  localparam logic [RA_W-1:0] R_QUAL = RA_W'(BASE + 3);
  localparam logic [RA_W-1:0] R_DATA = RA_W'(BASE + 4);
  localparam logic [RA_W-1:0] R_DMSK = RA_W'(BASE + 5);

  logic [AW-1:0] adr_q;
  logic [3:0]    msk_q;
  logic [IW-1:0] asid_q;
  logic [6:0]    qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q  <= '0;
      msk_q  <= '0;
      asid_q <= '0;
      qual_q <= '0;
    end else if (we_i) begin
      if (waddr_i == R_ADDR) adr_q  <= wdata_i[AW-1:0];
      if (waddr_i == R_MASK) msk_q  <= wdata_i[3:0];
      if (waddr_i == R_ASID) asid_q <= wdata_i[IW-1:0];
      if (waddr_i == R_QUAL) qual_q <= wdata_i[6:0];
    end
  end

  logic [2:0]    mcode;
  logic [4:0]    ign_n;
  logic [AW-1:0] amask;
  logic          addr_ok, asid_ok, sz_ok, dir_ok, typ_ok, data_ok;
  logic [RW-1:0] data_rd;

  assign mcode   = {msk_q[3], msk_q[1:0]};
  assign ign_n   = ign_width(mcode);
  assign amask   = (mcode == 3'b011) ? '1 : ((AW'(1) << ign_n) - AW'(1));
  assign addr_ok = ((cyc_addr_i ^ adr_q) & ~amask) == '0;
  assign asid_ok = msk_q[MSK_NOASID] || (cyc_asid_i == asid_q);
  assign sz_ok   = size_ok({qual_q[6], qual_q[1:0]}, cyc_size_i);
  assign dir_ok  = cyc_write_i ? qual_q[QL_WR] : qual_q[QL_RD];
  assign typ_ok  = cyc_insn_i ? qual_q[QL_INS] : qual_q[QL_DAT];

  generate
    if (HAS_DATA) begin : g_data
      logic [DW-1:0] dat_q, dmsk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dat_q  <= '0;
          dmsk_q <= '0;
        end else if (we_i) begin
          if (waddr_i == R_DATA) dat_q  <= wdata_i[DW-1:0];
          if (waddr_i == R_DMSK) dmsk_q <= wdata_i[DW-1:0];
        end
      end
      assign data_ok = !data_en_i || (((cyc_data_i ^ dat_q) & ~dmsk_q) == '0);
      assign data_rd = (raddr_i == R_DATA) ? RW'(dat_q) :
                       (raddr_i == R_DMSK) ? RW'(dmsk_q) : '0;
    end else begin : g_nodata
      logic unused_dat;
      assign unused_dat = ^{data_en_i, cyc_data_i};
      assign data_ok = 1'b1;
      assign data_rd = '0;
    end
  endgenerate

  assign hit_o = cyc_valid_i && addr_ok && asid_ok && sz_ok && dir_ok && typ_ok && data_ok;

  always_comb begin
    rdata_o = data_rd;
    if (raddr_i == R_ADDR) rdata_o = RW'(adr_q);
    if (raddr_i == R_MASK) rdata_o = RW'(msk_q);
    if (raddr_i == R_ASID) rdata_o = RW'(asid_q);
    if (raddr_i == R_QUAL) rdata_o = RW'(qual_q);
  end

  // R5: no direction or no type selected keeps the channel silent
  p_quiet_unprog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((qual_q[QL_WR:QL_RD] == 2'b00) || (qual_q[QL_DAT:QL_INS] == 2'b00)) |-> !hit_o);

  // R3: identifier enforced unless ignored
  p_asid_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !msk_q[MSK_NOASID]) |-> (cyc_asid_i == asid_q));

endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
#(
  parameter int unsigned RA_W    = 4,
  parameter int unsigned CTL_IDX = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RA_W-1:0] waddr_i,
  input  ctl_t            wctl_i,
  input  logic [RA_W-1:0] raddr_i,
  output logic [15:0]     rdata_o,
  input  logic            hit_a_i,
  input  logic            hit_b_i,
  input  logic            cyc_insn_i,
  input  logic            retire_i,
  output logic            data_en_o,
  output logic            brk_o
);

  localparam logic [RA_W-1:0] R_CTL = RA_W'(CTL_IDX);

  ctl_t ctl_q, ctl_d;
  seq_e seq_q, seq_d;
  logic pend_q, pend_d;
  logic ctl_we, a_clr, b_clr;
  logic a_aft, b_aft, armed, fire_seq, brk_now, brk_defer;

  assign ctl_we = we_i && (waddr_i == R_CTL);
  assign a_clr  = ctl_we && !wctl_i.a_flag;
  assign b_clr  = ctl_we && !wctl_i.b_flag;
  assign a_aft  = ctl_q.a_after && cyc_insn_i;
  assign b_aft  = ctl_q.b_after && cyc_insn_i;
  assign armed  = ctl_q.a_flag && (seq_q == SEQ_OPEN);

  always_comb begin
    fire_seq  = 1'b0;
    brk_now   = 1'b0;
    brk_defer = 1'b0;
    if (ctl_q.chain) begin
      fire_seq  = hit_b_i && armed;
      brk_now   = fire_seq && !b_aft;
      brk_defer = fire_seq && b_aft;
    end else begin
      brk_now   = (hit_a_i && !a_aft) || (hit_b_i && !b_aft);
      brk_defer = (hit_a_i && a_aft) || (hit_b_i && b_aft);
    end
  end

  assign brk_o     = brk_now || (pend_q && retire_i);
  assign data_en_o = ctl_q.b_data;

  always_comb begin
    ctl_d = ctl_we ? wctl_i : ctl_q;
    // hardware set beats a simultaneous software clear
    ctl_d.a_flag = hit_a_i || (ctl_q.a_flag && !a_clr);
    ctl_d.b_flag = hit_b_i || (ctl_q.b_flag && !b_clr);
    seq_d = seq_q;
    if (fire_seq)   seq_d = SEQ_SPENT;
    else if (a_clr) seq_d = SEQ_OPEN;
    pend_d = brk_defer || (pend_q && !retire_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      seq_q  <= SEQ_OPEN;
      pend_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      seq_q  <= seq_d;
      pend_q <= pend_d;
    end
  end

  assign rdata_o = (raddr_i == R_CTL) ? ctl_pack(ctl_q) : '0;

  // R10: flags stay set unless software clears them
  p_flag_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.a_flag && !ctl_we) |=> ctl_q.a_flag);
  p_hit_sets_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_b_i |=> ctl_q.b_flag);

  // R8: no chained break without an open armed sequence
  p_chain_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.chain && !ctl_q.a_flag && !pend_q) |-> !brk_o);
  p_spent_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.chain && (seq_q == SEQ_SPENT) && !pend_q) |-> !brk_o);

  // R9: fetch matches with after-timing never break before retire
  p_after_defer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.a_after && ctl_q.b_after && cyc_insn_i && !pend_q) |-> !brk_o);

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned IW      = 8,
  parameter int unsigned RW      = 32,
  parameter int unsigned RA_W    = 4,
  parameter int unsigned NCH     = 2,
  parameter int unsigned CH_SPAN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RA_W-1:0] reg_waddr_i,
  input  logic [RW-1:0]   reg_wdata_i,
  input  logic [RA_W-1:0] reg_raddr_i,
  output logic [RW-1:0]   reg_rdata_o,
  input  logic            cyc_valid_i,
  input  logic [AW-1:0]   cyc_addr_i,
  input  logic [IW-1:0]   cyc_asid_i,
  input  logic [1:0]      cyc_size_i,
  input  logic            cyc_write_i,
  input  logic            cyc_insn_i,
  input  logic [DW-1:0]   cyc_data_i,
  input  logic            retire_i,
  output logic            break_o
);

  // last channel carries the data compare and two extra registers
  localparam int unsigned CTL_IDX = NCH * CH_SPAN + 2;

  logic [NCH-1:0] ch_hit;
  logic [RW-1:0]  ch_rd [NCH];
  logic [15:0]    ctl_rd;
  logic           b_den;
  ctl_t           wctl;

  assign wctl = ctl_unpack(reg_wdata_i[15:0]);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      bkpt_chan #(
        .AW(AW), .DW(DW), .IW(IW), .RW(RW), .RA_W(RA_W),
        .BASE(i * CH_SPAN), .HAS_DATA(i == NCH - 1)
      ) u_chan (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (reg_we_i),
        .waddr_i     (reg_waddr_i),
        .wdata_i     (reg_wdata_i),
        .raddr_i     (reg_raddr_i),
        .rdata_o     (ch_rd[i]),
        .cyc_valid_i (cyc_valid_i),
        .cyc_addr_i  (cyc_addr_i),
        .cyc_asid_i  (cyc_asid_i),
        .cyc_size_i  (cyc_size_i),
        .cyc_write_i (cyc_write_i),
        .cyc_insn_i  (cyc_insn_i),
        .cyc_data_i  (cyc_data_i),
        .data_en_i   (b_den),
        .hit_o       (ch_hit[i])
      );
    end
  endgenerate

  bkpt_ctrl #(.RA_W(RA_W), .CTL_IDX(CTL_IDX)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .waddr_i    (reg_waddr_i),
    .wctl_i     (wctl),
    .raddr_i    (reg_raddr_i),
    .rdata_o    (ctl_rd),
    .hit_a_i    (ch_hit[0]),
    .hit_b_i    (ch_hit[NCH-1]),
    .cyc_insn_i (cyc_insn_i),
    .retire_i   (retire_i),
    .data_en_o  (b_den),
    .brk_o      (break_o)
  );

  always_comb begin
    reg_rdata_o = RW'(ctl_rd);
    for (int i = 0; i < NCH; i++) reg_rdata_o = reg_rdata_o | ch_rd[i];
  end

endmodule

// File: tb/sim_bkpt_unit.sv
module sim_bkpt_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [7:0]  cyc_asid = '0;
  logic [1:0]  cyc_size = '0;
  logic        cyc_write = 1'b0;
  logic        cyc_insn = 1'b0;
  logic [31:0] cyc_data = '0;
  logic        retire = 1'b0;
  logic        break_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bkpt_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_waddr_i(reg_waddr), .reg_wdata_i(reg_wdata),
    .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .cyc_valid_i(cyc_valid), .cyc_addr_i(cyc_addr), .cyc_asid_i(cyc_asid),
    .cyc_size_i(cyc_size), .cyc_write_i(cyc_write), .cyc_insn_i(cyc_insn),
    .cyc_data_i(cyc_data), .retire_i(retire), .break_o(break_w)
  );

  // reference model state
  logic [31:0] mr [0:10];
  bit m_spent = 0;
  bit m_pend = 0;

  function automatic logic [31:0] reg_width(input int idx);
    if (idx == 1 || idx == 5) return 32'h0000_000f;
    if (idx == 3 || idx == 7) return 32'h0000_007f;
    if (idx == 2 || idx == 6) return 32'h0000_00ff;
    if (idx == 10) return 32'h0000_c4c8;
    return 32'hffff_ffff;
  endfunction

  function automatic bit m_hit(input int b, input bit has_d);
    int n;
    logic [31:0] keep;
    logic [7:0] q;
    bit ok;
    case (mr[b+1][7:0] & 8'h0b)
      8'h01: n = 10;
      8'h02: n = 12;
      8'h08: n = 16;
      8'h09: n = 20;
      8'h03: n = 32;
      default: n = 0;
    endcase
    keep = (n == 32) ? 32'h0 : ~((32'h1 << n) - 32'h1);
    ok = cyc_valid && (((cyc_addr ^ mr[b]) & keep) == 0);
    ok = ok && (mr[b+1][2] || (cyc_asid == mr[b+2][7:0]));
    q = mr[b+3][7:0];
    case (q & 8'h43)
      8'h00: ;
      8'h01: ok = ok && (cyc_size == 2'd0);
      8'h02: ok = ok && (cyc_size == 2'd1);
      8'h03: ok = ok && (cyc_size == 2'd2);
      8'h40: ok = ok && (cyc_size == 2'd3);
      default: ok = 0;
    endcase
    ok = ok && (cyc_write ? q[3] : q[2]);
    ok = ok && (cyc_insn ? q[4] : q[5]);
    if (has_d && mr[10][7]) ok = ok && (((cyc_data ^ mr[8]) & ~mr[9]) == 0);
    return ok;
  endfunction

  task automatic step(input string tag);
    bit ha, hb, aa, ab, f, now, dfr, exp_b, cw;
    bit na, nb;
    logic [31:0] exp_rd;
    #1;
    ha = m_hit(0, 0);
    hb = m_hit(4, 1);
    aa = mr[10][10] && cyc_insn;
    ab = mr[10][6] && cyc_insn;
    f = 0;
    if (mr[10][3]) begin
      f = hb && mr[10][15] && !m_spent;
      now = f && !ab;
      dfr = f && ab;
    end else begin
      now = (ha && !aa) || (hb && !ab);
      dfr = (ha && aa) || (hb && ab);
    end
    exp_b = now || (m_pend && retire);
    exp_rd = (reg_raddr <= 10) ? mr[reg_raddr] : 32'h0;
    checks++;
    if (break_w !== exp_b) begin
      errors++;
      $display("FAIL %s break_o act=%b exp=%b t=%0t", tag, break_w, exp_b, $time);
    end
    checks++;
    if (reg_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata[%0d] act=%h exp=%h t=%0t", tag, reg_raddr, reg_rdata, exp_rd, $time);
    end
    cw = reg_we && reg_waddr == 10;
    na = ha || (mr[10][15] && !(cw && !reg_wdata[15]));
    nb = hb || (mr[10][14] && !(cw && !reg_wdata[14]));
    @(posedge clk);
    if (f) m_spent = 1;
    else if (cw && !reg_wdata[15]) m_spent = 0;
    m_pend = dfr || (m_pend && !retire);
    if (reg_we && reg_waddr <= 9) mr[reg_waddr] = reg_wdata & reg_width(int'(reg_waddr));
    if (cw) mr[10] = reg_wdata & 32'h0000_04c8;
    else    mr[10] = mr[10] & 32'h0000_04c8;
    mr[10][15] = na;
    mr[10][14] = nb;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    step(tag);
    reg_we = 0;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [7:0] id, input logic [1:0] sz,
                     input bit w, input bit ins, input logic [31:0] d, input string tag);
    cyc_valid = 1; cyc_addr = a; cyc_asid = id; cyc_size = sz;
    cyc_write = w; cyc_insn = ins; cyc_data = d;
    step(tag);
    cyc_valid = 0;
  endtask

  task automatic idle(input string tag);
    step(tag);
  endtask

  logic [7:0]  mcodes [0:7] = '{8'h04, 8'h05, 8'h06, 8'h0c, 8'h0d, 8'h07, 8'h0e, 8'h0f};
  logic [31:0] probes [0:5] = '{32'h1234_5678, 32'h1234_5400, 32'h1234_5000,
                                32'h1234_0000, 32'h1230_0000, 32'hffff_ffff};
  logic [7:0]  szq [0:5] = '{8'h01, 8'h02, 8'h03, 8'h40, 8'h41, 8'h00};

  initial begin
    for (int i = 0; i <= 10; i++) mr[i] = '0;
    #1 rst_ni = 0;
    repeat (3) @(negedge clk);
    // R1: reset state across the whole read space
    for (int a = 0; a < 16; a++) begin
      reg_raddr = 4'(a);
      #1;
      checks++;
      if (reg_rdata !== 32'h0) begin
        errors++;
        $display("FAIL R1 reset rdata[%0d] act=%h exp=0", a, reg_rdata);
      end
    end
    checks++;
    if (break_w !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset break_o act=%b exp=0", break_w);
    end
    @(negedge clk);
    rst_ni = 1;
    reg_raddr = 4'd10;
    // R1: unprogrammed channels stay silent for any cycle
    cyc(32'h0, 8'h0, 2'd0, 0, 0, 32'h0, "R1");
    cyc(32'h0, 8'h0, 2'd3, 1, 1, 32'h0, "R1");

    // R2 / R7: address mask codes on channel A
    wr(0, 32'h1234_5678, "R11");
    wr(3, 32'h3c, "R11");
    for (int c = 0; c < 8; c++) begin
      wr(1, {24'h0, mcodes[c]}, "R2");
      for (int p = 0; p < 6; p++) cyc(probes[p], 8'h77, 2'd2, 0, 0, 0, "R2");
      wr(10, 32'h0, "R10");
    end

    // R3: identifier compare
    wr(1, 32'h0, "R3");
    wr(2, 32'h5a, "R3");
    cyc(32'h1234_5678, 8'h5a, 2'd0, 0, 1, 0, "R3");
    cyc(32'h1234_5678, 8'h5b, 2'd0, 0, 1, 0, "R3");
    wr(10, 32'h0, "R10");
    wr(1, 32'h4, "R3");
    cyc(32'h1234_5678, 8'h5b, 2'd0, 0, 1, 0, "R3");
    wr(10, 32'h0, "R10");

    // R4: size qualifier
    for (int s = 0; s < 6; s++) begin
      wr(3, {24'h0, 8'h3c | szq[s]}, "R4");
      for (int z = 0; z < 4; z++) cyc(32'h1234_5678, 8'h0, 2'(z), 1, 0, 0, "R4");
      wr(10, 32'h0, "R10");
    end

    // R5: direction and type bits
    wr(3, 32'h14, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 0, 1, 0, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 1, 1, 0, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 0, 0, 0, "R5");
    wr(10, 32'h0, "R10");
    wr(3, 32'h30, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 0, 1, 0, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 1, 0, 0, "R5");
    wr(3, 32'h0c, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 0, 1, 0, "R5");
    cyc(32'h1234_5678, 8'h0, 2'd0, 1, 0, 0, "R5");
    wr(3, 32'h0, "R5");

    // R6: channel B data compare
    wr(4, 32'h8000_0000, "R11");
    wr(5, 32'h7, "R11");
    wr(7, 32'h3c, "R11");
    wr(8, 32'hcafe_0000, "R11");
    wr(9, 32'h0000_ffff, "R11");
    for (int a = 4; a <= 9; a++) begin
      reg_raddr = 4'(a);
      idle("R11");
    end
    reg_raddr = 4'd10;
    cyc(32'h0000_1000, 8'h0, 2'd2, 1, 0, 32'h1111_1111, "R6");
    wr(10, 32'h0080, "R6");
    cyc(32'h0000_1000, 8'h0, 2'd2, 1, 0, 32'hcafe_1234, "R6");
    cyc(32'h0000_1000, 8'h0, 2'd2, 1, 0, 32'hcaff_0000, "R6");
    cyc(32'h0000_1000, 8'h0, 2'd2, 1, 0, 32'h4afe_0000, "R6");

    // R10: write one keeps, write zero clears, set wins over clear
    wr(10, 32'hc080, "R10");
    idle("R10");
    wr(10, 32'h0080, "R10");
    idle("R10");
    reg_we = 1; reg_waddr = 4'd10; reg_wdata = 32'h0080;
    cyc(32'h0000_2000, 8'h0, 2'd2, 1, 0, 32'hcafe_0001, "R10");
    reg_we = 0;
    idle("R10");
    wr(10, 32'h0, "R10");

    // R8: chained sequence, A exact at 0x100, B any address
    wr(0, 32'h100, "R8");
    wr(1, 32'h4, "R8");
    wr(3, 32'h3c, "R8");
    wr(10, 32'h0008, "R8");
    cyc(32'h300, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h100, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h300, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h300, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h100, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h300, 8'h0, 2'd2, 0, 0, 0, "R8");
    wr(10, 32'h0008, "R8");
    cyc(32'h300, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h100, 8'h0, 2'd2, 0, 0, 0, "R8");
    cyc(32'h300, 8'h0, 2'd2, 0, 0, 0, "R8");

    // R9: after-execution timing, independent mode
    wr(10, 32'h0440, "R9");
    wr(7, 32'h0, "R9");
    cyc(32'h100, 8'h0, 2'd2, 0, 1, 0, "R9");
    idle("R9");
    retire = 1; idle("R9"); retire = 0;
    retire = 1; idle("R9"); retire = 0;
    cyc(32'h100, 8'h0, 2'd2, 0, 0, 0, "R9");
    cyc(32'h100, 8'h0, 2'd2, 0, 1, 0, "R9");
    retire = 1;
    cyc(32'h100, 8'h0, 2'd2, 0, 1, 0, "R9");
    idle("R9");
    retire = 0;
    idle("R9");
    wr(10, 32'h0400, "R7");
    cyc(32'h100, 8'h0, 2'd2, 0, 1, 0, "R7");
    wr(10, 32'h0000, "R7");
    cyc(32'h100, 8'h0, 2'd2, 0, 1, 0, "R7");

    // R9 with chaining: B deferred
    wr(7, 32'h3c, "R9");
    wr(10, 32'h0048, "R9");
    cyc(32'h100, 8'h0, 2'd2, 0, 1, 0, "R9");
    cyc(32'h300, 8'h0, 2'd2, 0, 1, 0, "R9");
    idle("R9");
    retire = 1; idle("R9"); retire = 0;
    idle("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule